// File: doc/BRIEF.md
# Programmable Display Timing Engine

This block drives horizontal sync, vertical sync, data-enable, a fetch-request pulse and a pixel value for a video panel. Software sets the timing through a simple synchronous register port. Horizontal timing comes from a counter that runs over the pixels of one line. Vertical timing comes from a second counter that runs over every pixel clock of the frame. Because of this, every vertical edge sits at an absolute pixel position. A programmable skew can place it part-way through a line.

Inside the display window the block can also apply an optional active sub-window. Pixels that are in the display window but outside an enabled sub-window carry a border colour. When the upstream source has no valid data, pixels inside the active area carry an underflow colour. A frame counter and a line counter can each be gated by software and read back. Timing registers are staged and are loaded into the working copy only at a frame boundary, or at any time while the engine is stopped.

Top module: `disp_timing_engine`

## Requirements
- R1: Register 2 holds the line period in bits [31:16] and the hsync width in bits [15:0]. The horizontal counter runs from 0 to period-1. hsync is active while this counter is below the width.
- R2: Register 3 holds the frame period in pixel clocks, register 4 the vsync width in pixel clocks and register 5 the skew. The frame counter wraps at the frame period. vsync is active while skew <= frame counter < skew + width.
- R3: data-enable is active when the horizontal counter lies within [start, end] of register 6 (end in [31:16], start in [15:0]) and the frame counter lies within [register 7, register 8]. The pixel output is pix_i inside this window and zero outside it.
- R4: Config register 1 bit 29 enables the horizontal active window (register 9, packed like register 6). Bit 30 enables the vertical active window (registers 10 to 11). Inside the display window but outside an enabled active window, the pixel output is the colour in register 13.
- R5: Inside the active area, when pix_valid_i is low, the pixel output is the colour in register 14.
- R6: Register 12 bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data-enable. This includes their idle levels.
- R7: When config bit 31 is set, fetch_o pulses for exactly one cycle each frame, at the frame counter value held in register 15.
- R8: Register 0 bit 0 runs the engine. Clearing it forces all outputs inactive and zeroes both counters, so the next start begins at pixel 0.
- R9: A timing register written while the engine runs affects the output only from the next frame start.
- R10: Register 16 bit 0 gates the frame counter (read at address 17) and bit 1 gates the line counter (read at address 18). The frame counter counts frame wraps. The line counter counts line wraps and clears at frame start. Both read as zero while the engine is stopped.
- R11: After reset all outputs are low and both counter reads return zero.
- R12: Writable registers sit at word addresses 0 to 16 and read back their written value one cycle after rd_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | pixel clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | ADDR_W | register write word address |
| wr_data_i | input | 32 | register write data |
| rd_en_i | input | 1 | register read strobe |
| rd_addr_i | input | ADDR_W | register read word address |
| rd_data_o | output | 32 | read data, one cycle after strobe |
| pix_i | input | PIX_W | upstream pixel |
| pix_valid_i | input | 1 | upstream pixel valid |
| hsync_o | output | 1 | horizontal sync |
| vsync_o | output | 1 | vertical sync |
| de_o | output | 1 | data-enable |
| fetch_o | output | 1 | fetch request pulse |
| pix_o | output | PIX_W | output pixel |

## Verification
Once the run bit is captured at a clock edge, pixel 0 of the frame appears on the outputs right after the following edge. Counter position k is therefore visible one edge later than k. The bench samples on the falling edge and starts its pixel index at the first falling edge after that second rising edge.

Read data is registered, so it is sampled one falling edge after the strobe. Counter reads are placed mid-line and mid-frame, well away from any wrap. Stop is checked two edges after the write. Idle polarity is checked three edges after the write, which allows for the staging and output registers. The mid-frame write in the shadowing test lands near pixel 22, and the bench switches its expected window exactly at pixel 60.

// File: rtl/dte_pkg.sv
package dte_pkg;
  localparam int HW = 16;
  localparam int FW = 32;
  localparam int CFG_ACT_H = 29;
  localparam int CFG_ACT_V = 30;
  localparam int CFG_FETCH = 31;

  localparam int REG_RUN    = 0;
  localparam int REG_CFG    = 1;
  localparam int REG_HCTL   = 2;
  localparam int REG_VPER   = 3;
  localparam int REG_VSW    = 4;
  localparam int REG_SKEW   = 5;
  localparam int REG_DHCTL  = 6;
  localparam int REG_DVS    = 7;
  localparam int REG_DVE    = 8;
  localparam int REG_AHCTL  = 9;
  localparam int REG_AVS    = 10;
  localparam int REG_AVE    = 11;
  localparam int REG_POL    = 12;
  localparam int REG_BORDER = 13;
  localparam int REG_UFLOW  = 14;
  localparam int REG_FETCH  = 15;
  localparam int REG_CNTEN  = 16;
  localparam int REG_FCNT   = 17;
  localparam int REG_LCNT   = 18;
  localparam int NUM_RW     = 17;

  typedef struct packed {
    logic [HW-1:0] h_period;
    logic [HW-1:0] hs_width;
    logic [HW-1:0] dh_start;
    logic [HW-1:0] dh_end;
    logic [HW-1:0] ah_start;
    logic [HW-1:0] ah_end;
    logic [FW-1:0] v_period;
    logic [FW-1:0] vs_width;
    logic [FW-1:0] skew;
    logic [FW-1:0] dv_start;
    logic [FW-1:0] dv_end;
    logic [FW-1:0] av_start;
    logic [FW-1:0] av_end;
    logic [FW-1:0] fetch_start;
    logic          act_h_en;
    logic          act_v_en;
    logic          fetch_en;
    logic [2:0]    pol;
  } timing_t;
endpackage

// File: rtl/dte_regs.sv
module dte_regs
  import dte_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int PIX_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  input  logic              frame_end_i,
  input  logic [FW-1:0]     frame_cnt_i,
  input  logic [FW-1:0]     line_cnt_i,
  output logic              run_o,
  output timing_t           tim_o,
  output logic [PIX_W-1:0]  border_o,
  output logic [PIX_W-1:0]  uflow_o,
  output logic [1:0]        cnt_en_o
);
  logic [31:0] rf_q [NUM_RW];
  timing_t stage;
  timing_t act_q;
  logic [31:0] rd_mux;

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rf
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rf_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(g)) rf_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    stage.h_period    = rf_q[REG_HCTL][31:16];
    stage.hs_width    = rf_q[REG_HCTL][15:0];
    stage.dh_end      = rf_q[REG_DHCTL][31:16];
    stage.dh_start    = rf_q[REG_DHCTL][15:0];
    stage.ah_end      = rf_q[REG_AHCTL][31:16];
    stage.ah_start    = rf_q[REG_AHCTL][15:0];
    stage.v_period    = rf_q[REG_VPER];
    stage.vs_width    = rf_q[REG_VSW];
    stage.skew        = rf_q[REG_SKEW];
    stage.dv_start    = rf_q[REG_DVS];
    stage.dv_end      = rf_q[REG_DVE];
    stage.av_start    = rf_q[REG_AVS];
    stage.av_end      = rf_q[REG_AVE];
    stage.fetch_start = rf_q[REG_FETCH];
    stage.act_h_en    = rf_q[REG_CFG][CFG_ACT_H];
    stage.act_v_en    = rf_q[REG_CFG][CFG_ACT_V];
    stage.fetch_en    = rf_q[REG_CFG][CFG_FETCH];
    stage.pol         = rf_q[REG_POL][2:0];
  end

  assign run_o    = rf_q[REG_RUN][0];
  assign border_o = rf_q[REG_BORDER][PIX_W-1:0];
  assign uflow_o  = rf_q[REG_UFLOW][PIX_W-1:0];
  assign cnt_en_o = rf_q[REG_CNTEN][1:0];
  assign tim_o    = act_q;

  // working copy follows staging only while stopped or on the last frame pixel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else if (!run_o || frame_end_i) act_q <= stage;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_RW; i++)
      if (rd_addr_i == ADDR_W'(i)) rd_mux = rf_q[i];
    if (rd_addr_i == ADDR_W'(REG_FCNT)) rd_mux = run_o ? frame_cnt_i : '0;
    if (rd_addr_i == ADDR_W'(REG_LCNT)) rd_mux = run_o ? line_cnt_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_mux;
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !frame_end_i) |=> $stable(act_q)); // R9
endmodule

// File: rtl/dte_counters.sv
module dte_counters
  import dte_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  timing_t       tim_i,
  input  logic [1:0]    cnt_en_i,
  output logic [HW-1:0] hcnt_o,
  output logic [FW-1:0] fpc_o,
  output logic          frame_end_o,
  output logic [FW-1:0] frame_cnt_o,
  output logic [FW-1:0] line_cnt_o
);
  logic [HW-1:0] hcnt_q;
  logic [FW-1:0] fpc_q, fcnt_q, lcnt_q;
  logic          line_end;

  assign frame_end_o = run_i && (fpc_q == tim_i.v_period - 1'b1);
  assign line_end    = run_i && (hcnt_q == tim_i.h_period - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      fpc_q  <= '0;
    end else if (!run_i || frame_end_o) begin
      hcnt_q <= '0;
      fpc_q  <= '0;
    end else begin
      fpc_q  <= fpc_q + 1'b1;
      hcnt_q <= line_end ? '0 : hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= '0;
      lcnt_q <= '0;
    end else if (!run_i) begin
      fcnt_q <= '0;
      lcnt_q <= '0;
    end else begin
      if (frame_end_o && cnt_en_i[0]) fcnt_q <= fcnt_q + 1'b1;
      if (frame_end_o) lcnt_q <= '0;
      else if (line_end && cnt_en_i[1]) lcnt_q <= lcnt_q + 1'b1;
    end
  end

  assign hcnt_o      = hcnt_q;
  assign fpc_o       = fpc_q;
  assign frame_cnt_o = fcnt_q;
  assign line_cnt_o  = lcnt_q;

  AST_HCNT_IN_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tim_i.h_period != '0) |-> (hcnt_q < tim_i.h_period)); // R1
  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (hcnt_q == '0 && fpc_q == '0)); // R8
  AST_LINE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> (lcnt_q == '0)); // R10
  AST_FRAME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !frame_end_o) |=> $stable(fcnt_q)); // R10
endmodule

// File: rtl/dte_out.sv
module dte_out
  import dte_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  timing_t          tim_i,
  input  logic [HW-1:0]    hcnt_i,
  input  logic [FW-1:0]    fpc_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] border_i,
  input  logic [PIX_W-1:0] uflow_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             fetch_o,
  output logic [PIX_W-1:0] pix_o
);
  logic hs_c, vs_c, de_c, in_act_c, fetch_c;
  logic [PIX_W-1:0] pix_c;
  logic hs_q, vs_q, de_q, fetch_q;
  logic [2:0] pol_q;
  logic [PIX_W-1:0] pix_q;

  always_comb begin
    hs_c     = hcnt_i < tim_i.hs_width;
    vs_c     = (fpc_i >= tim_i.skew) && (fpc_i < tim_i.skew + tim_i.vs_width);
    de_c     = (hcnt_i >= tim_i.dh_start) && (hcnt_i <= tim_i.dh_end) &&
               (fpc_i >= tim_i.dv_start) && (fpc_i <= tim_i.dv_end);
    in_act_c = (!tim_i.act_h_en || (hcnt_i >= tim_i.ah_start && hcnt_i <= tim_i.ah_end)) &&
               (!tim_i.act_v_en || (fpc_i >= tim_i.av_start && fpc_i <= tim_i.av_end));
    fetch_c  = tim_i.fetch_en && (fpc_i == tim_i.fetch_start);
    if (!de_c)            pix_c = '0;
    else if (!in_act_c)   pix_c = border_i;
    else if (!pix_valid_i) pix_c = uflow_i;
    else                  pix_c = pix_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q <= 1'b0; vs_q <= 1'b0; de_q <= 1'b0; fetch_q <= 1'b0;
      pix_q <= '0;  pol_q <= '0;
    end else begin
      pol_q <= tim_i.pol;
      if (!run_i) begin
        hs_q <= 1'b0; vs_q <= 1'b0; de_q <= 1'b0; fetch_q <= 1'b0;
        pix_q <= '0;
      end else begin
        hs_q <= hs_c; vs_q <= vs_c; de_q <= de_c; fetch_q <= fetch_c;
        pix_q <= pix_c;
      end
    end
  end

  assign hsync_o = hs_q ^ pol_q[0];
  assign vsync_o = vs_q ^ pol_q[1];
  assign de_o    = de_q ^ pol_q[2];
  assign fetch_o = fetch_q;
  assign pix_o   = pix_q;

  AST_BLANK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_q |-> (pix_q == '0)); // R3
  AST_FETCH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_q && tim_i.v_period > 1) |=> !fetch_q); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!de_q && !fetch_q && !hs_q && !vs_q)); // R8
endmodule

// File: rtl/disp_timing_engine.sv
module disp_timing_engine
  import dte_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int PIX_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              pix_valid_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              fetch_o,
  output logic [PIX_W-1:0]  pix_o
);
  timing_t          tim;
  logic             run, frame_end;
  logic [1:0]       cnt_en;
  logic [PIX_W-1:0] border, uflow;
  logic [HW-1:0]    hcnt;
  logic [FW-1:0]    fpc, frame_cnt, line_cnt;

  dte_regs #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_en_i, .rd_addr_i,
    .rd_data_o,
    .frame_end_i(frame_end), .frame_cnt_i(frame_cnt), .line_cnt_i(line_cnt),
    .run_o(run), .tim_o(tim), .border_o(border), .uflow_o(uflow),
    .cnt_en_o(cnt_en)
  );

  dte_counters u_cnt (
    .clk_i, .rst_ni, .run_i(run), .tim_i(tim), .cnt_en_i(cnt_en),
    .hcnt_o(hcnt), .fpc_o(fpc), .frame_end_o(frame_end),
    .frame_cnt_o(frame_cnt), .line_cnt_o(line_cnt)
  );

  dte_out #(.PIX_W(PIX_W)) u_out (
    .clk_i, .rst_ni, .run_i(run), .tim_i(tim), .hcnt_i(hcnt), .fpc_i(fpc),
    .pix_i, .pix_valid_i, .border_i(border), .uflow_i(uflow),
    .hsync_o, .vsync_o, .de_o, .fetch_o, .pix_o
  );
endmodule

// File: tb/disp_timing_engine_tb_top.sv
`timescale 1ns/1ps
module disp_timing_engine_tb_top;
  localparam int AW = 5;
  localparam logic [23:0] PIXV = 24'h3C5A96;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0, rd_en_i = 1'b0, pix_valid_i = 1'b1;
  logic [AW-1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [31:0] wr_data_i = '0, rd_data_o;
  logic [23:0] pix_i = PIXV, pix_o;
  logic hsync_o, vsync_o, de_o, fetch_o;

  int n_chk = 0, n_fail = 0;
  int hp = 10, hsw = 2, vp = 60, vsw = 10, skew = 3;
  int dhs = 4, dhe = 7, dvs = 23, dve = 52;
  int ahs = 5, ahe = 6, avs = 33, ave = 42, fst = 55;
  logic [31:0] cfg = '0;
  logic [2:0]  pol = '0;
  logic [23:0] border = 24'h112233, uflow = 24'hFF0000;

  always #4 clk_i = ~clk_i;

  disp_timing_engine #(.ADDR_W(AW), .PIX_W(24)) dut_i (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_en_i = 1'b1; rd_addr_i = AW'(a);
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic prog();
    wr(1, cfg);
    wr(2, {hp[15:0], hsw[15:0]});
    wr(3, vp); wr(4, vsw); wr(5, skew);
    wr(6, {dhe[15:0], dhs[15:0]});
    wr(7, dvs); wr(8, dve);
    wr(9, {ahe[15:0], ahs[15:0]});
    wr(10, avs); wr(11, ave);
    wr(12, {29'd0, pol});
    wr(13, {8'd0, border}); wr(14, {8'd0, uflow});
    wr(15, fst);
  endtask

  // expected {hs, vs, de, fetch, pix} for pixel k of a run
  function automatic logic [27:0] model(input int k);
    int h, f;
    logic hs, vs, de, inact, fe;
    logic [23:0] px;
    h = k % hp; f = k % vp;
    hs = h < hsw;
    vs = (f >= skew) && (f < skew + vsw);
    de = (h >= dhs) && (h <= dhe) && (f >= dvs) && (f <= dve);
    inact = (!cfg[29] || (h >= ahs && h <= ahe)) && (!cfg[30] || (f >= avs && f <= ave));
    fe = cfg[31] && (f == fst);
    if (!de) px = '0;
    else if (!inact) px = border;
    else if (!pix_valid_i) px = uflow;
    else px = PIXV;
    return {hs ^ pol[0], vs ^ pol[1], de ^ pol[2], fe, px};
  endfunction

  task automatic cmp_run(input int n, input string th, input string tv,
                         input string td, input string tp, input string tf);
    int eh = 0, ev = 0, ed = 0, ep = 0, ef = 0;
    logic [27:0] e;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      e = model(k);
      if (hsync_o !== e[27]) eh++;
      if (vsync_o !== e[26]) ev++;
      if (de_o    !== e[25]) ed++;
      if (fetch_o !== e[24]) ef++;
      if (pix_o   !== e[23:0]) ep++;
    end
    if (th != "") check(eh == 0, th, "hsync mismatch count", eh, 0);
    if (tv != "") check(ev == 0, tv, "vsync mismatch count", ev, 0);
    if (td != "") check(ed == 0, td, "de mismatch count", ed, 0);
    if (tp != "") check(ep == 0, tp, "pixel mismatch count", ep, 0);
    if (tf != "") check(ef == 0, tf, "fetch mismatch count", ef, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check({hsync_o, vsync_o, de_o, fetch_o} == 4'b0, "R11", "idle syncs", {hsync_o, vsync_o, de_o, fetch_o}, 0);
    check(pix_o == '0, "R11", "idle pixel", pix_o, 0);
    rd(17, d); check(d == 0, "R11", "frame count", d, 0);
    rd(18, d); check(d == 0, "R11", "line count", d, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(2, 32'hABCD_1234);
    rd(2, d); check(d == 32'hABCD_1234, "R12", "hsync ctl readback", d, 32'hABCD_1234);
    wr(15, 32'h0000_0777);
    rd(15, d); check(d == 32'h777, "R12", "fetch start readback", d, 32'h777);
  endtask

  task automatic t_main();
    prog();
    wr(0, 1);
    cmp_run(120, "R1", "R2", "R3", "R3", "");
  endtask

  task automatic t_stop();
    int bad = 0;
    wr(0, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if ({hsync_o, vsync_o, de_o, fetch_o} != 4'b0 || pix_o != '0) bad++;
    end
    check(bad == 0, "R8", "outputs active while stopped", bad, 0);
    wr(0, 1);
    cmp_run(60, "R8", "R8", "R8", "R8", "");
    wr(0, 0);
  endtask

  task automatic t_window();
    cfg = 32'h6000_0000;
    prog();
    wr(0, 1);
    cmp_run(60, "", "", "R4", "R4", "");
    wr(0, 0);
    pix_valid_i = 1'b0;
    wr(0, 1);
    cmp_run(60, "", "", "R5", "R5", "");
    wr(0, 0);
    pix_valid_i = 1'b1;
    cfg = '0;
  endtask

  task automatic t_polarity();
    pol = 3'b111;
    prog();
    repeat (3) @(negedge clk_i);
    check({hsync_o, vsync_o, de_o} == 3'b111, "R6", "idle levels inverted", {hsync_o, vsync_o, de_o}, 3'b111);
    wr(0, 1);
    cmp_run(60, "R6", "R6", "R6", "", "");
    wr(0, 0);
    pol = '0;
    prog();
  endtask

  task automatic t_fetch();
    int pulses = 0;
    logic [27:0] e;
    int ef = 0;
    cfg = 32'h8000_0000;
    prog();
    wr(0, 1);
    for (int k = 0; k < 120; k++) begin
      @(negedge clk_i);
      e = model(k);
      if (fetch_o !== e[24]) ef++;
      if (fetch_o) pulses++;
    end
    check(ef == 0, "R7", "fetch position mismatches", ef, 0);
    check(pulses == 2, "R7", "fetch pulses in two frames", pulses, 2);
    wr(0, 0);
    cfg = '0;
    prog();
  endtask

  task automatic t_shadow();
    int eo = 0, en = 0;
    logic [27:0] e;
    prog();
    wr(0, 1);
    for (int k = 0; k < 120; k++) begin
      @(negedge clk_i);
      if (k == 60) begin dhs = 3; dhe = 8; end
      e = model(k);
      if (de_o !== e[25] || pix_o !== e[23:0]) begin
        if (k < 60) eo++; else en++;
      end
      if (k == 20) begin wr_en_i = 1'b1; wr_addr_i = AW'(6); wr_data_i = {16'd8, 16'd3}; end
      if (k == 21) wr_en_i = 1'b0;
    end
    check(eo == 0, "R9", "current frame altered by write", eo, 0);
    check(en == 0, "R9", "next frame ignores write", en, 0);
    wr(0, 0);
    dhs = 4; dhe = 7;
    prog();
  endtask

  task automatic t_counters();
    logic [31:0] d;
    wr(16, 3);
    wr(0, 1);
    repeat (145) @(negedge clk_i);
    rd(17, d); check(d == 2, "R10", "frame count", d, 2);
    rd(18, d); check(d == 2, "R10", "line count", d, 2);
    wr(0, 0);
    wr(16, 1);
    wr(0, 1);
    repeat (145) @(negedge clk_i);
    rd(17, d); check(d == 2, "R10", "frame count line gated", d, 2);
    rd(18, d); check(d == 0, "R10", "line count gated off", d, 0);
    wr(0, 0);
    rd(17, d); check(d == 0, "R10", "frame count while stopped", d, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_readback();
    t_main();
    t_stop();
    t_window();
    t_polarity();
    t_fetch();
    t_shadow();
    t_counters();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog all requirements: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule